// File: doc/BRIEF.md
# Debounced 4x4 Keypad Scanner

This block scans a sixteen-key matrix keypad. It drives four active-low row lines and samples four column lines that idle high through external pull-ups. A pressed key pulls its column low while its row is driven low. The scanner steps through the rows one at a time. When a column reads low, the scanner holds that row and re-checks the same column for a programmable number of clock cycles. The key is accepted only if the column stays low for that whole interval.

An accepted key is reported as a hex code in the range 0 to F, together with a valid strobe that lasts one clock. The scanner then drives all rows low. It accepts no further key until every column has read high for a full debounce interval. Holding a key down therefore produces exactly one report. Short bounces during release do not start a second report.

The column lines pass through a two-flop synchronizer before any decision is made. The debounce length and the row dwell time are parameters counted in clock cycles. In use, the debounce length is set well below the roughly 20 ms minimum duration of a human key press.

Top module: `keypad_scanner`

## Requirements
- R1: After reset, `row_o` is 4'b1110, `key_valid_o` is 0 and `key_o` is 0.
- R2: While idle, exactly one row bit is low at a time. The low bit moves from bit 0 to bit 3 and wraps around, staying on each row for `ROW_DWELL` clocks (`ROW_DWELL` >= 3).
- R3: The reported code is 4*row + column. Row bit r low (`row_o` 1110, 1101, 1011, 0111 for r = 0..3) selects keys 4r..4r+3, and column bit c low selects key 4r+c.
- R4: A key is reported only after its column has read low for `DEBOUNCE_CYCLES` consecutive clocks with its row held. A closure that opens earlier, or a bouncing contact, produces no report.
- R5: `key_valid_o` is high for exactly one clock per report, and `key_o` carries the code in that same clock.
- R6: A key held down produces exactly one report, however long it is held.
- R7: From the clock after a report, all four rows are driven low. Scanning restarts at row 0 only after every column has read high for `DEBOUNCE_CYCLES` consecutive clocks. A shorter open period followed by a new closure produces no new report.
- R8: `key_o` keeps the last reported code between reports.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| col_i | input | 4 | Column lines from the keypad, low when pressed |
| row_o | output | 4 | Row lines to the keypad, active low |
| key_o | output | 4 | Code of the last accepted key |
| key_valid_o | output | 1 | One-clock strobe when a key is accepted |

## Verification
The hardest case to reach from the ports is release bounce: the columns go high for fewer than `DEBOUNCE_CYCLES` clocks after a report and then close again. Only a correct wait-for-release counter, which restarts whenever it sees a low column, suppresses a second report here. The bench models the keypad as a function of `row_o`, so a press is seen only under its own row, or under the all-low release pattern. It times its open and closed windows relative to the observed strobe to land inside the release wait. The same model is used to toggle a contact faster than the debounce length during press, and to sweep all sixteen keys.

// File: rtl/kp_pkg.sv
package kp_pkg;
  localparam int unsigned NUM_ROWS = 4;
  localparam int unsigned NUM_COLS = 4;
  localparam int unsigned ROW_W    = $clog2(NUM_ROWS);
  localparam int unsigned COL_W    = $clog2(NUM_COLS);
  localparam int unsigned KEY_W    = ROW_W + COL_W;

  typedef enum logic [1:0] {
    ST_SCAN     = 2'd0,
    ST_DEBOUNCE = 2'd1,
    ST_REPORT   = 2'd2,
    ST_RELEASE  = 2'd3
  } kp_state_e;
endpackage

// File: rtl/kp_sync.sv
module kp_sync #(
  parameter int unsigned WIDTH = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] meta_q, sync_q;

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        meta_q[i] <= 1'b1;  // idle-high lines
        sync_q[i] <= 1'b1;
      end else begin
        meta_q[i] <= d_i[i];
        sync_q[i] <= meta_q[i];
      end
    end
  end

  assign q_o = sync_q;
endmodule

// File: rtl/kp_row_drv.sv
module kp_row_drv
  import kp_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [ROW_W-1:0]    row_idx_i,
  input  logic                all_low_i,
  output logic [NUM_ROWS-1:0] row_o
);
  for (genvar r = 0; r < NUM_ROWS; r++) begin : g_row
    assign row_o[r] = !(all_low_i || (row_idx_i == ROW_W'(r)));
  end

  // R2
  one_row_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !all_low_i |-> ($countones(~row_o) == 1));
endmodule

// File: rtl/kp_ctrl.sv
module kp_ctrl
  import kp_pkg::*;
#(
  parameter int unsigned DEBOUNCE_CYCLES = 16,
  parameter int unsigned ROW_DWELL       = 4
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_COLS-1:0] col_i,
  output logic [ROW_W-1:0]    row_idx_o,
  output logic                all_low_o,
  output logic [KEY_W-1:0]    key_o,
  output logic                valid_o
);
  localparam int unsigned CNT_W = $clog2(DEBOUNCE_CYCLES + 1);
  localparam int unsigned DW_W  = $clog2(ROW_DWELL + 1);
  localparam logic [CNT_W-1:0] CNT_LAST   = CNT_W'(DEBOUNCE_CYCLES - 1);
  localparam logic [DW_W-1:0]  DWELL_LAST = DW_W'(ROW_DWELL - 1);
  localparam logic [NUM_COLS-1:0] COLS_IDLE = '1;

  kp_state_e        state_q, state_d;
  logic [ROW_W-1:0] row_q, row_d;
  logic [COL_W-1:0] col_q, col_d;
  logic [DW_W-1:0]  dwell_q, dwell_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [KEY_W-1:0] key_q, key_d;
  logic [COL_W-1:0] first_low;
  logic             any_low;

  // lowest-numbered low column
  always_comb begin
    first_low = '0;
    for (int c = NUM_COLS - 1; c >= 0; c--) begin
      if (!col_i[c]) first_low = COL_W'(c);
    end
  end
  assign any_low = (col_i != COLS_IDLE);

  always_comb begin
    state_d = state_q;
    row_d   = row_q;
    col_d   = col_q;
    dwell_d = dwell_q;
    cnt_d   = cnt_q;
    key_d   = key_q;
    unique case (state_q)
      ST_SCAN: begin
        if (dwell_q == DWELL_LAST) begin
          dwell_d = '0;
          if (any_low) begin
            state_d = ST_DEBOUNCE;
            col_d   = first_low;
            cnt_d   = '0;
          end else begin
            row_d = row_q + 1'b1;
          end
        end else begin
          dwell_d = dwell_q + 1'b1;
        end
      end
      ST_DEBOUNCE: begin
        if (col_i[col_q]) begin
          state_d = ST_SCAN;  // contact opened: rescan same row
          dwell_d = '0;
        end else if (cnt_q == CNT_LAST) begin
          state_d = ST_REPORT;
          key_d   = {row_q, col_q};
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      ST_REPORT: begin
        state_d = ST_RELEASE;
        cnt_d   = '0;
      end
      ST_RELEASE: begin
        if (any_low) begin
          cnt_d = '0;
        end else if (cnt_q == CNT_LAST) begin
          state_d = ST_SCAN;
          row_d   = '0;
          dwell_d = '0;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      default: state_d = ST_SCAN;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_SCAN;
      row_q   <= '0;
      col_q   <= '0;
      dwell_q <= '0;
      cnt_q   <= '0;
      key_q   <= '0;
    end else begin
      state_q <= state_d;
      row_q   <= row_d;
      col_q   <= col_d;
      dwell_q <= dwell_d;
      cnt_q   <= cnt_d;
      key_q   <= key_d;
    end
  end

  assign row_idx_o = row_q;
  assign all_low_o = (state_q == ST_RELEASE);
  assign key_o     = key_q;
  assign valid_o   = (state_q == ST_REPORT);

  // R5
  valid_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o);

  // R4
  report_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> $past(col_i != COLS_IDLE));

  // R4
  deb_row_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_DEBOUNCE) |=> $stable(row_q));

  // R7
  release_rows_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> all_low_o);

  // R6
  no_rearm_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (all_low_o && any_low) |=> !valid_o && (state_q != ST_SCAN));

  // R8
  key_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(key_o) |-> valid_o);
endmodule

// File: rtl/keypad_scanner.sv
module keypad_scanner
  import kp_pkg::*;
#(
  parameter int unsigned DEBOUNCE_CYCLES = 16,
  parameter int unsigned ROW_DWELL       = 4
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [3:0] col_i,
  output logic [3:0] row_o,
  output logic [3:0] key_o,
  output logic       key_valid_o
);
  logic [NUM_COLS-1:0] col_sync;
  logic [ROW_W-1:0]    row_idx;
  logic                all_low;

  kp_sync #(.WIDTH(NUM_COLS)) i_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (col_i),
    .q_o    (col_sync)
  );

  kp_ctrl #(
    .DEBOUNCE_CYCLES (DEBOUNCE_CYCLES),
    .ROW_DWELL       (ROW_DWELL)
  ) i_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .col_i     (col_sync),
    .row_idx_o (row_idx),
    .all_low_o (all_low),
    .key_o     (key_o),
    .valid_o   (key_valid_o)
  );

  kp_row_drv i_rows (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .row_idx_i (row_idx),
    .all_low_i (all_low),
    .row_o     (row_o)
  );
endmodule

// File: tb/test_keypad_scanner.sv
module test_keypad_scanner;
  localparam int CLK_PERIOD = 10;
  localparam int DEB   = 8;
  localparam int DWELL = 4;
  localparam int WAIT_MAX = 4 * DWELL * 4 + DEB + 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [3:0] col, row, key;
  logic key_valid;

  logic pressed = 1'b0;
  logic [3:0] pkey = '0;

  int checks = 0;
  int fails = 0;
  int vcount = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  // keypad model: pressed key pulls its column low when its row is low
  always_comb begin
    col = 4'hF;
    if (pressed && !row[pkey[3:2]]) col[pkey[1:0]] = 1'b0;
  end

  keypad_scanner #(.DEBOUNCE_CYCLES(DEB), .ROW_DWELL(DWELL)) i_keypad_scanner (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .col_i       (col),
    .row_o       (row),
    .key_o       (key),
    .key_valid_o (key_valid)
  );

  always @(negedge clk) if (rst_n && key_valid) vcount++;

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // returns 1 if a valid strobe is seen at a negedge within limit
  task automatic wait_valid(input int limit, output bit seen);
    seen = 1'b0;
    for (int i = 0; i < limit && !seen; i++) begin
      @(negedge clk);
      if (key_valid) seen = 1'b1;
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    bit seen;
    int v0;
    cycles(3);
    // R1 reset state
    check("R1 row", row, 4'b1110);
    check("R1 valid", key_valid, 0);
    check("R1 key", key, 0);
    rst_n = 1'b1;

    // R2 idle row rotation: after posedge k the row is (k/DWELL)%4
    for (int k = 0; k < 8 * DWELL; k++) begin
      if (k > 0) @(negedge clk);
      check("R2 row", row, 4'hF & ~(4'b1 << ((k / DWELL) % 4)));
    end

    // R3 R5 R7 R8 sweep over all keys
    for (int k = 0; k < 16; k++) begin
      pkey = 4'(k);
      pressed = 1'b1;
      v0 = vcount;
      wait_valid(WAIT_MAX, seen);
      check("R3 seen", int'(seen), 1);
      check("R3 code", key, k);
      @(negedge clk);
      check("R5 width", key_valid, 0);
      check("R7 rows low", row, 0);
      cycles(3);
      pressed = 1'b0;
      cycles(DEB + 10);
      check("R8 key held", key, k);
      check("R5 single", vcount - v0, 1);
    end

    // R4 short press never reported
    v0 = vcount;
    pkey = 4'h6;
    pressed = 1'b1;
    cycles(DEB / 2);
    pressed = 1'b0;
    cycles(WAIT_MAX);
    check("R4 short press", vcount - v0, 0);

    // R4 bouncing contact (period shorter than debounce), then stable
    v0 = vcount;
    pkey = 4'h9;
    for (int b = 0; b < 12; b++) begin
      pressed = ~pressed;
      cycles(3);
    end
    check("R4 bounce", vcount - v0, 0);
    pressed = 1'b1;
    wait_valid(WAIT_MAX, seen);
    check("R4 after settle", int'(seen), 1);
    check("R4 code", key, 9);

    // R6 long hold gives one report
    cycles(20 * DEB);
    check("R6 hold", vcount - v0, 1);

    // R7 release bounce shorter than debounce, then new closure
    pressed = 1'b0;
    cycles(DEB / 2);
    pkey = 4'hD;
    pressed = 1'b1;
    cycles(WAIT_MAX);
    check("R7 glitch release", vcount - v0, 1);
    check("R7 rows low", row, 0);
    check("R8 key kept", key, 9);

    // R7 full release re-arms scanning at row 0
    pressed = 1'b0;
    cycles(DEB + 3);
    check("R7 rescan row0", row, 4'b1110);
    pressed = 1'b1;
    wait_valid(WAIT_MAX, seen);
    check("R7 rearm", int'(seen), 1);
    check("R3 code D", key, 13);
    pressed = 1'b0;
    cycles(DEB + 5);

    summary();
  end
endmodule